// File: doc/BRIEF.md
# Mixed-Decay PWM Chopper Controller

This block runs the constant-current chopping loop for one motor winding. A free-running chopping oscillator delivers one-cycle ticks. A chopping counter divides them into fixed periods. Every period opens in charge, with current driven into the coil. When the external current comparator reports that the target has been reached, the controller moves into decay. It stays in slow decay first, with both low-side switches on. For a selectable closing part of the period it then uses fast decay, with the bridge reversed so that coil energy returns to the supply.

A step-clock pulse means the target current is about to change. It makes the chopping counter restart at the next oscillator tick, so that a fresh period, beginning with a short charge burst, lines up with the new target. The enable input gates only the four bridge switches. The counter and the phase sequencing keep running while the bridge is off. Every change of bridge pattern passes through one system clock with all switches open, so that the two switches of one leg are never on together.

Top module: `mixed_decay_chopper`

## Requirements
- R1: The bridge patterns are {sw_hi_a, sw_hi_b, sw_lo_a, sw_lo_b} = 1001 for charge, 0011 for slow decay, 0110 for fast decay and 0000 for off. All switches are off during reset, and a leg's high and low switches are never on together.
- R2: Between two different non-off patterns there is at least one cycle of 0000. Each phase change therefore costs exactly one output cycle, and a 64-cycle period has one off cycle for each phase it passes through.
- R3: A chopping period is 16 oscillator ticks, and each period starts in charge. With the comparator never high, the charge pattern is driven for all 64 cycles of a period at one tick every 4 clocks, with no off cycles.
- R4: For the first 4 system clocks of every charge phase the comparator is ignored. With the comparator held high, the charge pattern is seen for exactly 4 cycles in each period.
- R5: With full_fast low, decay_sel chooses how many of the period's closing ticks use fast decay: 00 none (slow only), 01 the last 2 ticks, 10 the last 4, 11 the last 8. With the comparator held high, a 64-cycle period shows charge/slow/fast/off counts of 4/58/0/2, 4/51/6/3, 4/43/14/3 and 4/27/30/3.
- R6: With full_fast high, the whole decay after the comparator trip is fast decay (counts 4/0/58/2).
- R7: If the comparator trips while the counter is already inside the fast window, the controller goes from charge directly to fast decay and skips slow decay.
- R8: A step pulse makes the chopping counter restart at the first tick sampled after the step's cycle, whichever phase is active. Charge is seen 2 clocks after that tick edge and lasts 4 cycles, followed by one off cycle and then slow decay.
- R9: With enable low, all four switches are off from the cycle after enable is sampled low. The period timing continues, so after re-enable the bridge resumes in the phase that the undisturbed period would have.
- R10: Within a period the phases only advance: slow decay follows charge, and fast decay follows charge or slow decay. Only a new period or a restart returns the bridge to charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse at each rising edge of the chopping oscillator |
| cur_hit | input | 1 | Current comparator output, high when coil current is at or above target |
| step_pulse | input | 1 | One-cycle step-clock event |
| enable | input | 1 | Bridge enable; low opens all switches |
| decay_sel | input | 2 | Fast-decay share of the period (00 none, 01 1/8, 10 1/4, 11 1/2) |
| full_fast | input | 1 | Use fast decay for the whole decay phase |
| sw_hi_a | output | 1 | Leg A high-side switch |
| sw_hi_b | output | 1 | Leg B high-side switch |
| sw_lo_a | output | 1 | Leg A low-side switch |
| sw_lo_b | output | 1 | Leg B low-side switch |

## Verification
On every cycle, the assertions check that no leg shorts and that each pattern change passes through an off cycle. They also check that the bridge opens in the cycle after enable is sampled low, and that within a period decay only moves forward, from charge to slow to fast. The bench's scenarios are needed for everything tied to time spent in a phase: the blanking length, the share of fast decay for each decay_sel value and for full_fast, and a late comparator trip skipping slow decay. The same holds for the restart timing after a step pulse in each phase, and for the period alignment kept across a disable.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,
    PH_CHARGE = 2'd1,
    PH_SLOW   = 2'd2,
    PH_FAST   = 2'd3
  } chop_phase_t;

  typedef struct packed {
    logic hi_a;
    logic hi_b;
    logic lo_a;
    logic lo_b;
  } bridge_t;

  function automatic bridge_t phase_to_bridge(input chop_phase_t ph);
    bridge_t b;
    b = '0;
    case (ph)
      PH_CHARGE: begin b.hi_a = 1'b1; b.lo_b = 1'b1; end
      PH_SLOW:   begin b.lo_a = 1'b1; b.lo_b = 1'b1; end
      PH_FAST:   begin b.hi_b = 1'b1; b.lo_a = 1'b1; end
      default:   b = '0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int PERIOD_TICKS = 16,
  parameter int CNT_W        = $clog2(PERIOD_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             step_pulse,
  output logic [CNT_W-1:0] cnt,
  output logic             period_start
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             restart, wrap, cnt_en;

  assign restart = osc_tick & pend_q;
  assign wrap    = osc_tick & (cnt_q == LAST);
  assign cnt_en  = osc_tick;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (wrap)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    pend_d = (pend_q & ~restart) | step_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign cnt          = cnt_q;
  assign period_start = restart | wrap;

endmodule

// File: rtl/chop_window.sv
module chop_window #(
  parameter int PERIOD_TICKS = 16,
  parameter int CNT_W        = $clog2(PERIOD_TICKS)
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       decay_sel,
  input  logic             full_fast,
  output logic             in_fast
);
  localparam logic [CNT_W:0] PER = (CNT_W+1)'(PERIOD_TICKS);

  logic [CNT_W:0] fast_ticks;
  logic [CNT_W:0] fast_from;

  always_comb begin
    case (decay_sel)
      2'b01:   fast_ticks = PER >> 3;
      2'b10:   fast_ticks = PER >> 2;
      2'b11:   fast_ticks = PER >> 1;
      default: fast_ticks = '0;
    endcase
  end

  always_comb begin
    if (full_fast)
      fast_from = '0;
    else
      fast_from = PER - fast_ticks;
  end

  assign in_fast = ({1'b0, cnt} >= fast_from);

endmodule

// File: rtl/chop_phase_fsm.sv
module chop_phase_fsm
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 4,
  parameter int BLK_W     = $clog2(BLANK_CYC + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        period_start,
  input  logic        in_fast,
  input  logic        cur_hit,
  output chop_phase_t phase
);
  localparam logic [BLK_W-1:0] BLANK_LD = BLK_W'(BLANK_CYC);

  chop_phase_t      ph_q, ph_d;
  logic [BLK_W-1:0] blank_q, blank_d;

  always_comb begin
    ph_d    = ph_q;
    blank_d = blank_q;
    if (period_start) begin
      ph_d    = PH_CHARGE;
      blank_d = BLANK_LD;
    end else begin
      case (ph_q)
        PH_CHARGE: begin
          if (blank_q != '0)
            blank_d = blank_q - 1'b1;
          else if (cur_hit)
            ph_d = in_fast ? PH_FAST : PH_SLOW;
        end
        PH_SLOW: begin
          if (in_fast)
            ph_d = PH_FAST;
        end
        PH_FAST: begin
          ph_d = PH_FAST;
        end
        default: begin
          ph_d    = PH_CHARGE;
          blank_d = BLANK_LD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_CHARGE;
      blank_q <= BLANK_LD;
    end else begin
      ph_q    <= ph_d;
      blank_q <= blank_d;
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/chop_nonoverlap.sv
module chop_nonoverlap
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  chop_phase_t want,
  output bridge_t     bridge
);
  chop_phase_t drv_q, drv_d;
  logic        gap_q, gap_d;

  always_comb begin
    drv_d = drv_q;
    gap_d = 1'b0;
    if (gap_q)
      drv_d = want;
    else if (want != drv_q)
      gap_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= PH_OFF;
      gap_q <= 1'b0;
    end else begin
      drv_q <= drv_d;
      gap_q <= gap_d;
    end
  end

  assign bridge = gap_q ? '0 : phase_to_bridge(drv_q);

endmodule

// File: rtl/mixed_decay_chopper.sv
module mixed_decay_chopper
  import chop_pkg::*;
#(
  parameter int PERIOD_TICKS = 16,
  parameter int BLANK_CYC    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       cur_hit,
  input  logic       step_pulse,
  input  logic       enable,
  input  logic [1:0] decay_sel,
  input  logic       full_fast,
  output logic       sw_hi_a,
  output logic       sw_hi_b,
  output logic       sw_lo_a,
  output logic       sw_lo_b
);
  localparam int CNT_W = $clog2(PERIOD_TICKS);
  localparam int BLK_W = $clog2(BLANK_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             period_start;
  logic             in_fast;
  chop_phase_t      phase;
  chop_phase_t      want;
  bridge_t          bridge;

  chop_timer #(.PERIOD_TICKS(PERIOD_TICKS), .CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_tick     (osc_tick),
    .step_pulse   (step_pulse),
    .cnt          (cnt),
    .period_start (period_start)
  );

  chop_window #(.PERIOD_TICKS(PERIOD_TICKS), .CNT_W(CNT_W)) u_window (
    .cnt       (cnt),
    .decay_sel (decay_sel),
    .full_fast (full_fast),
    .in_fast   (in_fast)
  );

  chop_phase_fsm #(.BLANK_CYC(BLANK_CYC), .BLK_W(BLK_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .in_fast      (in_fast),
    .cur_hit      (cur_hit),
    .phase        (phase)
  );

  assign want = enable ? phase : PH_OFF;

  chop_nonoverlap u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .want   (want),
    .bridge (bridge)
  );

  assign sw_hi_a = bridge.hi_a;
  assign sw_hi_b = bridge.hi_b;
  assign sw_lo_a = bridge.lo_a;
  assign sw_lo_b = bridge.lo_b;

endmodule

// File: rtl/chop_checker.sv
module chop_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sw_hi_a,
  input logic sw_hi_b,
  input logic sw_lo_a,
  input logic sw_lo_b
);
  localparam logic [3:0] P_CHG  = 4'b1001;
  localparam logic [3:0] P_SLOW = 4'b0011;
  localparam logic [3:0] P_FAST = 4'b0110;

  logic [3:0] pat;
  logic [3:0] last_q;

  assign pat = {sw_hi_a, sw_hi_b, sw_lo_a, sw_lo_b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      last_q <= 4'b0000;
    else if (!enable)
      last_q <= 4'b0000;
    else if (pat != 4'b0000)
      last_q <= pat;
  end

  // R1: a leg never has both switches closed
  a_r1_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_hi_a && sw_lo_a) && !(sw_hi_b && sw_lo_b));

  // R2: a non-off pattern is followed by itself or by all-off
  a_r2_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (pat != 4'b0000) |=> (pat == 4'b0000) || (pat == $past(pat)));

  // R9: enable sampled low opens the bridge on the next cycle
  a_r9_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pat == 4'b0000));

  // R10: slow decay is entered only from charge
  a_r10_slow_order: assert property (@(posedge clk) disable iff (!rst_n)
    (pat == P_SLOW && last_q != 4'b0000 && last_q != P_SLOW) |-> (last_q == P_CHG));

  // R10: fast decay is entered only from charge or slow decay
  a_r10_fast_order: assert property (@(posedge clk) disable iff (!rst_n)
    (pat == P_FAST && last_q != 4'b0000 && last_q != P_FAST) |->
      (last_q == P_CHG || last_q == P_SLOW));

endmodule

bind mixed_decay_chopper chop_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .enable  (enable),
  .sw_hi_a (sw_hi_a),
  .sw_hi_b (sw_hi_b),
  .sw_lo_a (sw_lo_a),
  .sw_lo_b (sw_lo_b)
);

// File: tb/sim_mixed_decay_chopper.sv
`timescale 1ns/1ps
module sim_mixed_decay_chopper;
  localparam int P  = 16;  // ticks per period
  localparam int T  = 4;   // clocks per tick
  localparam int B  = 4;   // blanking clocks
  localparam int PC = P * T;

  localparam int PAT_CHG  = 9;  // 1001
  localparam int PAT_SLOW = 3;  // 0011
  localparam int PAT_FAST = 6;  // 0110

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       cur_hit = 1'b0;
  logic       step_pulse = 1'b0;
  logic       enable = 1'b1;
  logic [1:0] decay_sel = 2'b00;
  logic       full_fast = 1'b0;
  logic       sw_hi_a, sw_hi_b, sw_lo_a, sw_lo_b;

  int cyc = 0;
  int ps = 0;
  int hit_mode = 1;   // 0 never, 1 always, 2 only late in period
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  mixed_decay_chopper #(.PERIOD_TICKS(P), .BLANK_CYC(B)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cur_hit(cur_hit),
    .step_pulse(step_pulse), .enable(enable), .decay_sel(decay_sel),
    .full_fast(full_fast), .sw_hi_a(sw_hi_a), .sw_hi_b(sw_hi_b),
    .sw_lo_a(sw_lo_a), .sw_lo_b(sw_lo_b)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic int pat_now();
    return int'({sw_hi_a, sw_hi_b, sw_lo_a, sw_lo_b});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_edge(input int e);
    do @(negedge clk); while (cyc < e);
  endtask

  // oscillator ticks and comparator stimulus, driven between edges
  initial begin
    forever begin
      @(negedge clk);
      osc_tick = rst_n && (((cyc + 1) % T) == 0);
      case (hit_mode)
        0: cur_hit = 1'b0;
        1: cur_hit = 1'b1;
        default: cur_hit = (cyc >= ps) && ((((cyc - ps) / T) % P) >= 12);
      endcase
    end
  end

  task automatic measure(input int start, output int ch, output int sl,
                         output int fa, output int off);
    ch = 0; sl = 0; fa = 0; off = 0;
    for (int i = 0; i < PC; i++) begin
      wait_edge(start + i);
      case (pat_now())
        PAT_CHG:  ch++;
        PAT_SLOW: sl++;
        PAT_FAST: fa++;
        default:  off++;
      endcase
    end
  endtask

  task automatic expect_counts(input int sel, input bit full, output int ch,
                               output int sl, output int fa, output int off);
    int f, chd, sld, fad;
    f = full ? P : ((sel == 0) ? 0 : (P >> (4 - sel)));
    chd = B + 1;
    if (full) begin fad = PC - chd; sld = 0; end
    else if (f == 0) begin sld = PC - chd; fad = 0; end
    else begin fad = T * f - 1; sld = PC - chd - fad; end
    ch  = chd - 1;
    sl  = (sld > 0) ? sld - 1 : 0;
    fa  = (fad > 0) ? fad - 1 : 0;
    off = 1 + ((sld > 0) ? 1 : 0) + ((fad > 0) ? 1 : 0);
  endtask

  initial begin
    int ch, sl, fa, off, ech, esl, efa, eoff, e, seen;
    int offs[3];
    offs[0] = 0; offs[1] = 9; offs[2] = 52;

    repeat (3) @(negedge clk);
    // R1: reset state is all switches off
    chk(pat_now() == 0, "R1 reset off", pat_now(), 0);
    rst_n = 1'b1;

    // R4 R5 R6 R2: fast-decay share sweep with the comparator held high
    ps = PC;
    for (int c = 0; c < 5; c++) begin
      wait_edge(ps);
      hit_mode  = 1;
      decay_sel = (c < 4) ? 2'(c) : 2'b00;
      full_fast = (c == 4);
      measure(ps + PC, ch, sl, fa, off);
      expect_counts((c < 4) ? c : 0, c == 4, ech, esl, efa, eoff);
      chk(ch == ech, "R4 charge cycles", ch, ech);
      chk(sl == esl, (c == 4) ? "R6 slow cycles" : "R5 slow cycles", sl, esl);
      chk(fa == efa, (c == 4) ? "R6 fast cycles" : "R5 fast cycles", fa, efa);
      chk(off == eoff, "R2 off cycles", off, eoff);
      ps += 2 * PC;
    end

    // R3: comparator never trips, charge all period
    wait_edge(ps);
    hit_mode = 0; decay_sel = 2'b10; full_fast = 1'b0;
    measure(ps + PC, ch, sl, fa, off);
    chk(ch == PC, "R3 charge whole period", ch, PC);
    chk(off == 0, "R3 no off cycles", off, 0);
    ps += 2 * PC;

    // R7: trip inside the fast window skips slow decay
    wait_edge(ps);
    hit_mode = 2; decay_sel = 2'b11;
    measure(ps + PC, ch, sl, fa, off);
    chk(sl == 0, "R7 no slow", sl, 0);
    chk(off == 2, "R7 off cycles", off, 2);
    ps += 2 * PC;

    // R8 R10: step restart during charge, slow and fast
    wait_edge(ps);
    hit_mode = 1; decay_sel = 2'b10;
    ps += PC;
    for (int k = 0; k < 3; k++) begin
      wait_edge(ps + offs[k]);
      if (k == 2) chk(pat_now() == PAT_FAST, "R5 fast before step", pat_now(), PAT_FAST);
      step_pulse = 1'b1;
      wait_edge(ps + offs[k] + 1);
      step_pulse = 1'b0;
      seen = offs[k] + 1;
      e = ps + T * (seen / T + 1);
      wait_edge(e + 2);
      chk(pat_now() == PAT_CHG, "R8 charge after restart", pat_now(), PAT_CHG);
      wait_edge(e + 5);
      chk(pat_now() == PAT_CHG, "R8 charge held", pat_now(), PAT_CHG);
      wait_edge(e + 6);
      chk(pat_now() == 0, "R8 gap after charge", pat_now(), 0);
      wait_edge(e + 7);
      chk(pat_now() == PAT_SLOW, "R10 slow follows charge", pat_now(), PAT_SLOW);
      ps = e + PC;
    end

    // R9: disable and resume with period timing kept
    wait_edge(ps + 20);
    enable = 1'b0;
    wait_edge(ps + 21);
    chk(pat_now() == 0, "R9 off after disable", pat_now(), 0);
    measure(ps + 22, ch, sl, fa, off);
    chk(off == PC, "R9 stays off", off, PC);
    wait_edge(ps + 2 * PC + 60);
    enable = 1'b1;
    wait_edge(ps + 2 * PC + 62);
    chk(pat_now() == PAT_FAST, "R9 resumes in fast", pat_now(), PAT_FAST);
    wait_edge(ps + 3 * PC + 2);
    chk(pat_now() == PAT_CHG, "R9 period aligned", pat_now(), PAT_CHG);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule